// File: doc/BRIEF.md
# Exception Priority and Take Controller

This block sits beside the completion logic of a pipelined core and decides, cycle by cycle, whether a pending exception is taken and which one. Request pulses from six classes are latched into pending flags: hard reset, machine check, soft reset, maskable asynchronous interrupts, instruction-fetch faults, and faults reported by the oldest in-flight instruction. Each class has its own condition for being taken. Some classes are taken at once. Others wait for the core to reach a recoverable state, for a clean completion, or for the pipeline to drain.

The block counts instructions between dispatch and completion, so it knows when the pipeline is empty. It drives a one-hot take vector that is high for a single cycle per exception. It also drives a sticky checkstop and two halt controls: one stops new dispatch and one freezes completion while a take is being set up. When an exception is taken, the pipeline is flushed, so the in-flight count returns to zero.

Top module: `exc_take_ctrl`

## Requirements
- R1: `take` has at most one bit set. Each bit is high for exactly one cycle per request. The taken class's pending flag clears on the following edge, unless a new request arrives on that same edge. Lower-ranked pending flags are kept.
- R2: A pulse on `hrst_req` or `por_req` gives `take[0]` in the cycle after the edge that samples it. This happens regardless of the recoverable state or of any other request. The same take clears every pending flag, the checkstop and the in-flight count.
- R3: A pending machine check is taken on `take[1]` when `me_en` is 1, even when the core is not recoverable. When `me_en` is 0, `checkstop` rises instead and stays high until a hard reset. While `checkstop` is high, no class other than hard reset is taken, and `disp_halt` and `cmpl_halt` are both high.
- R4: The core is recoverable only when all of these hold: `ri_en` is 1, `stq_empty` is 1, `stq_cancel` is 0 and `cmpl_open` is 0. Soft reset, asynchronous interrupts and fetch faults are taken only while the core is recoverable.
- R5: The ranking from highest to lowest is: hard reset, machine check, soft reset, head-instruction fault, asynchronous interrupt, fetch fault. When several classes can be taken, they are taken one per cycle in that order.
- R6: `head_exc` raised while at least one instruction is in flight gives `take[3]`, without waiting for the recoverable state. The take flushes the in-flight count to zero.
- R7: When an asynchronous interrupt is pending and instructions are in flight, the interrupt waits. After a clean completion (`cmpl_pulse` with `head_exc` low), `cmpl_halt` rises, and the interrupt is taken on `take[4]` once the core is recoverable. If the head instruction excepts first, `take[3]` is taken and the interrupt stays pending. With an empty pipeline, the interrupt needs only the recoverable state.
- R8: A pending fetch fault holds `disp_halt` high. The fault is taken on `take[5]` once the in-flight count is zero and the core is recoverable. A `take[3]` discards it.
- R9: Bit positions of `take` and `pend`: 0 hard reset, 1 machine check, 2 soft reset, 3 head-instruction fault, 4 asynchronous interrupt, 5 fetch fault. `pend[3]` shows `head_exc` while instructions are in flight. After reset, `take`, `pend`, `checkstop` and both halts are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hrst_req | input | 1 | Hard reset request pulse |
| por_req | input | 1 | Power-on reset request pulse |
| mchk_req | input | 1 | Machine check request pulse |
| srst_req | input | 1 | Soft reset request pulse |
| irq_req | input | IRQ_N | Maskable asynchronous interrupt pulses |
| ifetch_req | input | 1 | Instruction-fetch fault pulse |
| me_en | input | 1 | Machine-check enable |
| ri_en | input | 1 | Recoverable-interrupt enable |
| stq_empty | input | 1 | Completed-store queue is empty |
| stq_cancel | input | 1 | Store queue emptied by cancellation |
| cmpl_open | input | 1 | An instruction signalled to complete has not finished |
| disp_pulse | input | 1 | One instruction dispatched |
| cmpl_pulse | input | 1 | One instruction completed |
| head_exc | input | 1 | Oldest in-flight instruction reports a fault |
| take | output | 6 | One-hot exception take |
| checkstop | output | 1 | Sticky checkstop |
| disp_halt | output | 1 | Stop dispatching |
| cmpl_halt | output | 1 | Stop completing |
| pend | output | 6 | Pending status per class |

## Verification
Some properties are checked by assertions on every cycle:
- `take` is one-hot.
- A taken class clears its pending flag.
- A machine check is never taken with `me_en` low.
- Checkstop is sticky and blocks every take except hard reset.
- Recovery-gated classes never fire outside the recoverable state.
- A head-instruction fault discards a fetch fault.
- A hard reset clears all state.

Other behaviour depends on sequences, and only the bench scenarios can show it:
- the order in which simultaneous requests drain;
- an interrupt waiting for a clean completion and then holding completion;
- an interrupt surviving a competing head fault;
- a fetch fault being taken only after the pipeline has drained.

// File: rtl/exc_take_ctrl.sv
module exc_take_ctrl #(
  parameter int IRQ_N = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hrst_req,
  input  logic             por_req,
  input  logic             mchk_req,
  input  logic             srst_req,
  input  logic [IRQ_N-1:0] irq_req,
  input  logic             ifetch_req,
  input  logic             me_en,
  input  logic             ri_en,
  input  logic             stq_empty,
  input  logic             stq_cancel,
  input  logic             cmpl_open,
  input  logic             disp_pulse,
  input  logic             cmpl_pulse,
  input  logic             head_exc,
  output logic [5:0]       take,
  output logic             checkstop,
  output logic             disp_halt,
  output logic             cmpl_halt,
  output logic [5:0]       pend
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic hr_p, mc_p, sr_p, irq_p, if_p, cs, armed;
  logic [CNT_W-1:0] cnt;
  logic [5:0] elig;

  wire recov  = ri_en & stq_empty & ~stq_cancel & ~cmpl_open;
  wire empty  = (cnt == '0);
  wire quiet  = ~cs & ~mc_p;
  wire cs_set = mc_p & ~me_en & ~cs;
  wire any_tk = |take;

  assign elig[0] = hr_p;
  assign elig[1] = mc_p & me_en & ~cs;
  assign elig[2] = sr_p & recov & quiet;
  assign elig[3] = head_exc & ~empty & quiet;
  assign elig[4] = irq_p & (armed | empty) & recov & quiet;
  assign elig[5] = if_p & empty & recov & quiet;

  assign take      = elig & (~elig + 6'd1);
  assign checkstop = cs;
  assign disp_halt = if_p | cs;
  assign cmpl_halt = (irq_p & armed) | cs;
  assign pend      = {if_p, irq_p, head_exc & ~empty, sr_p, mc_p, hr_p};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_p  <= 1'b0;
      mc_p  <= 1'b0;
      sr_p  <= 1'b0;
      irq_p <= 1'b0;
      if_p  <= 1'b0;
      cs    <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else if (take[0]) begin
      hr_p  <= hrst_req | por_req;
      mc_p  <= 1'b0;
      sr_p  <= 1'b0;
      irq_p <= 1'b0;
      if_p  <= 1'b0;
      cs    <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      hr_p  <= hrst_req | por_req;
      cs    <= cs | cs_set;
      mc_p  <= ((mc_p & ~take[1] & ~cs_set) | mchk_req) & ~cs & ~cs_set;
      sr_p  <= (sr_p & ~take[2]) | srst_req;
      irq_p <= (irq_p & ~take[4]) | (|irq_req);
      if_p  <= (if_p & ~take[5] & ~take[3]) | ifetch_req;
      if (any_tk)
        armed <= 1'b0;
      else if (irq_p & cmpl_pulse & ~head_exc & ~empty)
        armed <= 1'b1;
      if (any_tk)
        cnt <= '0;
      else if (disp_pulse & ~cmpl_pulse & (cnt != CNT_MAX))
        cnt <= cnt + CNT_ONE;
      else if (cmpl_pulse & ~disp_pulse & ~empty)
        cnt <= cnt - CNT_ONE;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take[2] && !srst_req |=> !pend[2]);

  p_hard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take[0] && !srst_req && !ifetch_req && (irq_req == '0) && !mchk_req
    |=> !checkstop && !pend[1] && !pend[2] && !pend[4] && !pend[5]);

  p_mchk_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take[1] |-> me_en);

  p_cs_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop && !take[0] |=> checkstop);

  p_cs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |-> (take[5:1] == 5'b0) && disp_halt && cmpl_halt);

  p_recov_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take[2] || take[4] || take[5]) |-> ri_en && stq_empty && !stq_cancel && !cmpl_open);

  p_drop_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take[3] && !ifetch_req |=> !pend[5]);
endmodule

// File: tb/test_exc_take_ctrl.sv
module test_exc_take_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hrst_req = 0, por_req = 0, mchk_req = 0, srst_req = 0, ifetch_req = 0;
  logic [3:0] irq_req = '0;
  logic me_en = 1, ri_en = 1, stq_empty = 1, stq_cancel = 0, cmpl_open = 0;
  logic disp_pulse = 0, cmpl_pulse = 0, head_exc = 0;
  logic [5:0] take, pend;
  logic checkstop, disp_halt, cmpl_halt;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [5:0] expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  exc_take_ctrl #(.IRQ_N(4), .CNT_W(4)) i_exc_take_ctrl (
    .clk(clk), .rst_n(rst_n), .hrst_req(hrst_req), .por_req(por_req),
    .mchk_req(mchk_req), .srst_req(srst_req), .irq_req(irq_req),
    .ifetch_req(ifetch_req), .me_en(me_en), .ri_en(ri_en),
    .stq_empty(stq_empty), .stq_cancel(stq_cancel), .cmpl_open(cmpl_open),
    .disp_pulse(disp_pulse), .cmpl_pulse(cmpl_pulse), .head_exc(head_exc),
    .take(take), .checkstop(checkstop), .disp_halt(disp_halt),
    .cmpl_halt(cmpl_halt), .pend(pend));

  task automatic want(input logic [5:0] v, input string tag);
    expq.push_back(v);
    tagq.push_back(tag);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic look();
    @(negedge clk);
    #4;
  endtask

  // monitor: samples just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && take != 6'b0) begin
        total++;
        if (expq.size() == 0) begin
          bad++;
          $display("FAIL R1 unexpected take actual=%b expected=000000", take);
        end else begin
          logic [5:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (take !== e) begin
            bad++;
            $display("FAIL %s take actual=%b expected=%b", t, take, e);
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look();
    chk("R9 reset take", {2'b0, take}, 8'h00);
    chk("R9 reset pend", {2'b0, pend}, 8'h00);
    chk("R9 reset flags", {5'b0, checkstop, disp_halt, cmpl_halt}, 8'h00);

    // R2 hard reset and power-on, ignoring recoverability
    ri_en = 0; stq_cancel = 1;
    want(6'b000001, "R2 hreset");
    @(negedge clk) hrst_req = 1;
    @(negedge clk) hrst_req = 0;
    want(6'b000001, "R2 por");
    @(negedge clk) por_req = 1;
    @(negedge clk) por_req = 0;
    look();
    chk("R2 pend clear", {2'b0, pend}, 8'h00);

    // R3 machine check while not recoverable
    want(6'b000010, "R3 mchk taken nonrecoverable");
    @(negedge clk) mchk_req = 1;
    @(negedge clk) mchk_req = 0;

    // R4 soft reset waits for recoverable state
    @(negedge clk) srst_req = 1;
    @(negedge clk) srst_req = 0;
    repeat (3) look();
    chk("R4 srst held", {7'b0, pend[2]}, 8'h01);
    @(negedge clk) ri_en = 1;
    repeat (2) look();
    chk("R4 srst still held by cancel", {7'b0, pend[2]}, 8'h01);
    want(6'b000100, "R4 srst when recoverable");
    @(negedge clk) stq_cancel = 0;
    look();
    @(negedge clk) cmpl_open = 1; srst_req = 1;
    @(negedge clk) srst_req = 0;
    repeat (2) look();
    chk("R4 srst held by open completion", {7'b0, pend[2]}, 8'h01);
    want(6'b000100, "R4 srst after completion");
    @(negedge clk) cmpl_open = 0;
    look();

    // R5 ranking of simultaneous requests
    ri_en = 0;
    @(negedge clk) srst_req = 1; irq_req = 4'b0100; ifetch_req = 1;
    @(negedge clk) srst_req = 0; irq_req = 0; ifetch_req = 0; mchk_req = 1;
    @(negedge clk) mchk_req = 0;
    want(6'b000010, "R5 mchk first");
    look();
    chk("R5 lower pend kept", {2'b0, pend}, 8'b00110100);
    want(6'b000100, "R5 srst second");
    want(6'b010000, "R5 irq third");
    want(6'b100000, "R5 fetch fourth");
    @(negedge clk) ri_en = 1;
    repeat (4) look();
    chk("R5 all drained", {2'b0, pend}, 8'h00);

    // R7/R6 head fault beats a waiting interrupt
    @(negedge clk) disp_pulse = 1;
    @(negedge clk);
    @(negedge clk) disp_pulse = 0; irq_req = 4'b0001;
    @(negedge clk) irq_req = 0;
    look();
    chk("R7 irq waits with instructions in flight", {6'b0, pend[4], cmpl_halt}, 8'b10);
    want(6'b001000, "R6 head fault");
    want(6'b010000, "R7 irq after head fault");
    @(negedge clk) head_exc = 1;
    @(negedge clk) head_exc = 0;
    repeat (2) look();

    // R7 clean completion arms the interrupt
    @(negedge clk) disp_pulse = 1;
    @(negedge clk);
    @(negedge clk) disp_pulse = 0; ri_en = 0; irq_req = 4'b1000;
    @(negedge clk) irq_req = 0; cmpl_pulse = 1;
    @(negedge clk) cmpl_pulse = 0;
    look();
    chk("R7 completion halted", {7'b0, cmpl_halt}, 8'h01);
    want(6'b010000, "R7 irq taken when recoverable");
    @(negedge clk) ri_en = 1;
    look();
    look();
    chk("R7 halt released", {7'b0, cmpl_halt}, 8'h00);

    // R8 fetch fault waits for drain
    @(negedge clk) disp_pulse = 1;
    @(negedge clk);
    @(negedge clk) disp_pulse = 0; ifetch_req = 1;
    @(negedge clk) ifetch_req = 0;
    look();
    chk("R8 dispatch halted", {7'b0, disp_halt}, 8'h01);
    @(negedge clk) cmpl_pulse = 1;
    @(negedge clk) cmpl_pulse = 0;
    look();
    chk("R8 fetch still pending", {7'b0, pend[5]}, 8'h01);
    want(6'b100000, "R8 fetch after drain");
    @(negedge clk) cmpl_pulse = 1;
    @(negedge clk) cmpl_pulse = 0;
    repeat (2) look();

    // R8 head fault discards the fetch fault
    @(negedge clk) disp_pulse = 1;
    @(negedge clk) disp_pulse = 0; ifetch_req = 1;
    @(negedge clk) ifetch_req = 0;
    want(6'b001000, "R8 head fault discards fetch");
    @(negedge clk) head_exc = 1;
    @(negedge clk) head_exc = 0;
    repeat (3) look();
    chk("R8 fetch discarded", {6'b0, pend[5], disp_halt}, 8'h00);

    // R3 checkstop path
    @(negedge clk) me_en = 0; mchk_req = 1;
    @(negedge clk) mchk_req = 0;
    repeat (2) look();
    chk("R3 checkstop", {5'b0, checkstop, disp_halt, cmpl_halt}, 8'b111);
    @(negedge clk) me_en = 1; srst_req = 1;
    @(negedge clk) srst_req = 0;
    repeat (3) look();
    chk("R3 checkstop sticky, srst blocked", {6'b0, checkstop, pend[2]}, 8'b11);
    want(6'b000001, "R3 hreset leaves checkstop");
    @(negedge clk) hrst_req = 1;
    @(negedge clk) hrst_req = 0;
    repeat (2) look();
    chk("R2 hreset clears checkstop and pend", {1'b0, checkstop, pend}, 8'h00);

    repeat (4) look();
    chk("R1 all expected takes seen", expq.size(), 8'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule